// File: doc/BRIEF.md
# UART Parity and Error-Flag Unit

This block is a register-mapped slice of a UART core. It moves one serial word at a time between a simple register bus and a pair of serial pins. When parity is on, the most significant bit of the word carries the parity bit in place of a data bit, so no extra bit is added to the frame. Every frame is a low start bit, then 8 or 9 bits sent LSB first, then a high stop bit. The receiver checks the parity bit and the stop bit. Each problem it finds sets a sticky flag, and that flag can drive an interrupt.

Software clears a flag in two steps: it reads the status word, then it accesses the data word. Any other register access between the two steps cancels the clear. A flag that was still clear when the status word was read survives the data access that follows. The bus takes one access per cycle (`bus_rd` or `bus_wr`), has no back-pressure and returns read data in the same cycle. Received data is not streamed: it sits in the data register until the next frame replaces it.

Register word index (`bus_addr`): 0 status, 1 data, 2 baud divisor, 3 control. Control bits: 0 enable, 1 nine-bit word, 2 parity on, 3 odd parity, 4 parity-interrupt enable, 5 error-interrupt enable. One oversampling tick occurs every divisor+1 clocks, and one bit lasts 16 ticks.

Top module: `uart_perr_unit`

## Requirements
- R1: After reset, the status, data, divisor and control registers all read as zero, `txd` is high and `irq` is low.
- R2: A data-register read returns the last received word in bits 8:0 and zeros in bits 31:9. Status bit 2 shows that an unread word is present, and a data read clears it.
- R3: A data write while enabled and idle sends a low start bit, then 8 data bits (control bit 1 = 0) or 9 data bits (control bit 1 = 1) LSB first, then a high stop bit. Status bit 3 is high while the frame is being sent.
- R4: With parity on, bit 7 (8-bit words) or bit 8 (9-bit words) is replaced by the parity of the bits below it. For even parity (control bit 3 = 0) the number of ones, including the parity bit, is even. For odd parity it is odd.
- R5: With parity on, a received word whose top bit does not match the parity of the bits below it sets status bit 0.
- R6: A received frame whose stop bit samples low sets status bit 1.
- R7: A low pulse on `rxd` shorter than half a bit is treated as noise. It stores no word and sets no flag.
- R8: A status read followed at once by a data read clears both flags. A status read followed at once by a data write clears only status bit 0.
- R9: Any other register access between the status read and the data access cancels the clear.
- R10: A flag that was clear when the status word was read is not cleared by the data access that follows.
- R11: `irq` is high when status bit 0 is set and control bit 4 is set, or when status bit 1 is set and control bit 5 is set. Otherwise it is low.
- R12: A divisor write while control bit 0 is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Error interrupt |

## Verification
The transmitter is tried with random words under every mix of word length, parity on or off, and parity sense. This separates the bit that gets replaced in 8-bit words from the one replaced in 9-bit words, and even parity from odd. The receiver gets random frames with injected parity and stop-bit faults, so each flag must respond only to its own fault. Directed access orders cover the clear sequence: status then data read, status then data write, an access placed in between, and a flag that arrives after the status read. Together they separate the rules for clearing each flag. A short noise pulse, the two interrupt enables and a divisor write while enabled cover the remaining requirements.

// File: rtl/uart_pe_pkg.sv
package uart_pe_pkg;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_DATA = 2'd1,
    A_BAUD = 2'd2,
    A_CTRL = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } ser_state_e;

  // control bit 0 is en, bit 5 is err_ie
  typedef struct packed {
    logic err_ie;
    logic par_ie;
    logic odd;
    logic par_en;
    logic wl9;
    logic en;
  } ctrl_t;

  // parity over the bits below the top bit of the word
  function automatic logic par_of(input logic [8:0] w, input logic wl9, input logic odd);
    logic p;
    p = wl9 ? ^w[7:0] : ^w[6:0];
    return p ^ odd;
  endfunction

  function automatic logic [8:0] with_parity(input logic [8:0] w, input logic wl9,
                                             input logic pen, input logic odd);
    logic [8:0] r;
    r = w;
    if (pen) begin
      if (wl9) r[8] = par_of(w, 1'b1, odd);
      else     r[7] = par_of(w, 1'b0, odd);
    end
    return r;
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && run) |=> !tick);
endmodule

// File: rtl/uart_tx_par.sv
module uart_tx_par
  import uart_pe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [8:0] word,
  input  logic       wl9,
  output logic       busy,
  output logic       txd
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  ser_state_e st;
  logic [8:0] sh;
  logic [3:0] idx;
  logic [CW-1:0] cnt;
  logic wl_q, line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; idx <= '0; cnt <= '0; wl_q <= 1'b0; line <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (load) begin
          st <= S_START; sh <= word; wl_q <= wl9; cnt <= '0; line <= 1'b0;
        end
        S_START: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0; idx <= '0; line <= sh[0]; sh <= sh >> 1; st <= S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (idx == (wl_q ? 4'd8 : 4'd7)) begin
              st <= S_STOP; line <= 1'b1;
            end else begin
              line <= sh[0]; sh <= sh >> 1; idx <= idx + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign txd  = line;

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/uart_rx_par.sv
module uart_rx_par
  import uart_pe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       rxd,
  input  logic       wl9,
  input  logic       par_en,
  input  logic       odd,
  output logic       done,
  output logic [8:0] word,
  output logic       perr,
  output logic       ferr
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

  ser_state_e st;
  logic [1:0] sync;
  logic rx_s, wl_q;
  logic [8:0] sh, aligned;
  logic [3:0] idx;
  logic [CW-1:0] cnt;

  assign rx_s    = sync[1];
  assign aligned = wl_q ? sh : {1'b0, sh[8:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; idx <= '0; cnt <= '0; wl_q <= 1'b0;
      done <= 1'b0; word <= '0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
      if (!run) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st <= S_START; cnt <= '0; wl_q <= wl9;
          end
          S_START: if (tick) begin
            if (cnt == HALF) begin
              cnt <= '0; idx <= '0; sh <= '0;
              st <= rx_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: if (tick) begin
            if (cnt == LAST) begin
              cnt <= '0; sh <= {rx_s, sh[8:1]};
              if (idx == (wl_q ? 4'd8 : 4'd7)) st <= S_STOP;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: if (tick) begin
            if (cnt == LAST) begin
              cnt  <= '0; st <= S_IDLE; done <= 1'b1; word <= aligned;
              perr <= par_en && ((wl_q ? aligned[8] : aligned[7]) != par_of(aligned, wl_q, odd));
              ferr <= !rx_s;
            end else cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr || ferr) |-> done);
endmodule

// File: rtl/uart_perr_unit.sv
module uart_perr_unit
  import uart_pe_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  ctrl_t ctrl_q;
  logic [DIV_W-1:0] baud_q;
  logic [8:0] rx_data;
  logic rx_avail, pe_q, fe_q, armed_q, snap_pe, snap_fe;
  logic tick, tx_busy, tx_load, rx_done, rx_perr, rx_ferr;
  logic [8:0] rx_word;
  logic stat_rd, data_rd, data_wr, any_acc, clr_pe, clr_fe;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[31:9];
  assign any_acc = bus_rd || bus_wr;
  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign data_rd = bus_rd && (bus_addr == A_DATA);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign tx_load = data_wr && ctrl_q.en && !tx_busy;
  assign clr_pe  = armed_q && snap_pe && (data_rd || data_wr);
  assign clr_fe  = armed_q && snap_fe && data_rd;

  uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .div(baud_q), .tick(tick));

  uart_tx_par #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
    .word(with_parity(bus_wdata[8:0], ctrl_q.wl9, ctrl_q.par_en, ctrl_q.odd)),
    .wl9(ctrl_q.wl9), .busy(tx_busy), .txd(txd));

  uart_rx_par #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .tick(tick), .rxd(rxd),
    .wl9(ctrl_q.wl9), .par_en(ctrl_q.par_en), .odd(ctrl_q.odd),
    .done(rx_done), .word(rx_word), .perr(rx_perr), .ferr(rx_ferr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; baud_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[5:0]);
      if (bus_addr == A_BAUD && !ctrl_q.en) baud_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0; rx_avail <= 1'b0;
    end else if (rx_done) begin
      rx_data <= rx_word; rx_avail <= 1'b1;
    end else if (data_rd) rx_avail <= 1'b0;
  end

  // clear sequence: a status read arms and takes a snapshot, the next access decides
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0; snap_pe <= 1'b0; snap_fe <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0;
    end else begin
      if (stat_rd) begin
        armed_q <= 1'b1; snap_pe <= pe_q; snap_fe <= fe_q;
      end else if (any_acc) armed_q <= 1'b0;
      if (rx_perr)     pe_q <= 1'b1;
      else if (clr_pe) pe_q <= 1'b0;
      if (rx_ferr)     fe_q <= 1'b1;
      else if (clr_fe) fe_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (reg_addr_e'(bus_addr))
        A_STAT:  bus_rdata[3:0] = {tx_busy, rx_avail, fe_q, pe_q};
        A_DATA:  bus_rdata[8:0] = rx_data;
        A_BAUD:  bus_rdata[DIV_W-1:0] = baud_q;
        default: bus_rdata[5:0] = ctrl_q;
      endcase
    end
  end

  assign irq = (pe_q && ctrl_q.par_ie) || (fe_q && ctrl_q.err_ie);

  p_baud_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && bus_wr && bus_addr == A_BAUD) |=> $stable(baud_q));
  p_pe_clear_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pe_q) |-> $past(armed_q && any_acc && bus_addr == A_DATA));
  p_fe_clear_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_q) |-> $past(armed_q && bus_rd && bus_addr == A_DATA));
  p_late_flag_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_q && !snap_pe) |=> pe_q);
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.par_ie && !ctrl_q.err_ie) |-> !irq);
endmodule

// File: tb/sim_uart_perr_unit.sv
`timescale 1ns/1ps
module sim_uart_perr_unit;
  localparam int DIV   = 3;
  localparam int TICKC = DIV + 1;
  localparam int BITC  = 16 * TICKC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rxd = 1'b1;
  logic txd, irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_perr_unit u0 (.clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  function automatic logic [8:0] exp_word(input logic [8:0] d, input bit wl9,
                                          input bit pen, input bit odd);
    logic [8:0] r;
    int n, c;
    n = wl9 ? 9 : 8;
    r = wl9 ? d : {1'b0, d[7:0]};
    if (pen) begin
      c = 0;
      for (int i = 0; i < n - 1; i++) c += int'(r[i]);
      r[n-1] = ((c % 2) == 1) ^ odd;
    end
    return r;
  endfunction

  function automatic logic [31:0] ctrl_word(input bit en, input bit wl9, input bit pen,
                                            input bit odd, input bit pie, input bit eie);
    return {26'd0, eie, pie, odd, pen, wl9, en};
  endfunction

  task automatic send(input logic [8:0] w, input int n, input bit stop_ok);
    @(negedge clk); rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = w[i];
      repeat (BITC) @(negedge clk);
    end
    if (stop_ok) begin
      rxd = 1'b1; repeat (BITC) @(negedge clk);
    end else begin
      rxd = 1'b0; repeat (10 * TICKC) @(negedge clk);
      rxd = 1'b1; repeat (2 * BITC) @(negedge clk);
    end
    rxd = 1'b1; repeat (BITC) @(negedge clk);
  endtask

  task automatic capture(input int n, output logic [8:0] w, output logic st, output logic sp);
    int t;
    t = 0; w = '0;
    while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    repeat (8 * TICKC) @(negedge clk);
    st = txd;
    for (int i = 0; i < n; i++) begin
      repeat (BITC) @(negedge clk);
      w[i] = txd;
    end
    repeat (BITC) @(negedge clk);
    sp = txd;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic clear_flags();
    logic [31:0] d;
    rd(0, d); rd(1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [8:0] w, dat, ew;
    logic st, sp;
    bit wl9, pen, odd, flip, sok;
    int n;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(0, d); chk("R1 status", d, 32'h0);
    rd(1, d); chk("R1 data", d, 32'h0);
    rd(2, d); chk("R1 divisor", d, 32'h0);
    rd(3, d); chk("R1 control", d, 32'h0);
    chk("R1 txd", {31'd0, txd}, 32'h1);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    wr(2, DIV);
    rd(2, d); chk("R12 divisor written while disabled", d, DIV);
    wr(3, ctrl_word(1, 0, 0, 0, 0, 0));
    wr(2, 32'h7);
    rd(2, d); chk("R12 divisor write ignored while enabled", d, DIV);

    // R3 R4: random transmit
    for (int k = 0; k < 12; k++) begin
      wl9 = $urandom % 2; pen = $urandom % 2; odd = $urandom % 2;
      n = wl9 ? 9 : 8;
      dat = 9'($urandom);
      wr(3, ctrl_word(1, wl9, pen, odd, 0, 0));
      wr(1, {23'd0, dat});
      capture(n, w, st, sp);
      chk("R3 start bit", {31'd0, st}, 32'h0);
      chk("R3 stop bit", {31'd0, sp}, 32'h1);
      chk("R4 tx word", {23'd0, w}, {23'd0, exp_word(dat, wl9, pen, odd)});
    end
    // R4 directed: odd parity, 9-bit, all zeros -> top bit set
    wr(3, ctrl_word(1, 1, 1, 1, 0, 0));
    wr(1, 32'h0);
    capture(9, w, st, sp);
    chk("R4 odd nine-bit zero word", {23'd0, w}, 32'h100);
    // R3 busy flag
    wr(3, ctrl_word(1, 0, 0, 0, 0, 0));
    wr(1, 32'h55);
    rd(0, d); chk("R3 busy while sending", {31'd0, d[3]}, 32'h1);
    repeat (12 * BITC) @(negedge clk);
    rd(0, d); chk("R3 idle after frame", {31'd0, d[3]}, 32'h0);

    // R2 R5 R6 R8: random receive with fault injection
    for (int k = 0; k < 12; k++) begin
      wl9 = $urandom % 2; pen = $urandom % 2; odd = $urandom % 2;
      flip = ($urandom % 3) == 0; sok = ($urandom % 4) != 0;
      n = wl9 ? 9 : 8;
      dat = 9'($urandom);
      ew = exp_word(dat, wl9, pen, odd);
      if (pen && flip) ew[n-1] = ~ew[n-1];
      wr(3, ctrl_word(1, wl9, pen, odd, 0, 0));
      send(ew, n, sok);
      rd(0, d);
      chk("R5 parity flag", {31'd0, d[0]}, {31'd0, pen && flip});
      chk("R6 framing flag", {31'd0, d[1]}, {31'd0, !sok});
      chk("R2 word present", {31'd0, d[2]}, 32'h1);
      rd(1, d); chk("R2 received word", d, {23'd0, ew});
      rd(0, d); chk("R8 flags cleared by status then data read", {29'd0, d[2:0]}, 32'h0);
    end

    // R7: short noise pulse
    @(negedge clk); rxd = 1'b0;
    repeat (3 * TICKC) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    rd(0, d); chk("R7 noise ignored", {29'd0, d[2:0]}, 32'h0);

    // R8: data write clears parity flag only
    wr(3, ctrl_word(1, 0, 1, 0, 0, 0));
    send(9'h0FE, 8, 0);
    rd(0, d); chk("R8 both flags set", {30'd0, d[1:0]}, 32'h3);
    wr(1, 32'h0);
    rd(0, d); chk("R8 write clears parity only", {30'd0, d[1:0]}, 32'h2);
    rd(1, d);
    rd(0, d); chk("R8 read clears framing", {30'd0, d[1:0]}, 32'h0);
    repeat (12 * BITC) @(negedge clk);

    // R9: intervening access disarms
    send(9'h001, 8, 1);
    rd(0, d); rd(3, d); rd(1, d);
    rd(0, d); chk("R9 clear cancelled", {31'd0, d[0]}, 32'h1);
    rd(1, d);
    rd(0, d); chk("R9 clear after rearm", {31'd0, d[0]}, 32'h0);

    // R10: flag raised after the status read survives
    rd(0, d);
    send(9'h001, 8, 1);
    rd(1, d);
    rd(0, d); chk("R10 late flag kept", {31'd0, d[0]}, 32'h1);
    rd(1, d);

    // R11: interrupt gating
    wr(3, ctrl_word(1, 0, 1, 0, 1, 0));
    send(9'h001, 8, 1);
    chk("R11 parity irq enabled", {31'd0, irq}, 32'h1);
    wr(3, ctrl_word(1, 0, 1, 0, 0, 1));
    chk("R11 parity irq masked", {31'd0, irq}, 32'h0);
    clear_flags();
    send(9'h003, 8, 0);
    chk("R11 framing irq enabled", {31'd0, irq}, 32'h1);
    wr(3, ctrl_word(1, 0, 1, 0, 1, 0));
    chk("R11 framing irq masked", {31'd0, irq}, 32'h0);
    clear_flags();
    chk("R11 irq low after clear", {31'd0, irq}, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule